// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Timing Engine

This block sequences the control pins of an asynchronous static memory for one read or one write at a time. A requester presents an address, write data, a direction flag and a chip-select index on a valid/ready handshake. The block then drives one active-low chip-select line, the active-low write and output enables, the address bus and the data-out bus. The timing of each transfer is set by a small set of cycle counts. These counts are captured when the request is accepted, so they may be reprogrammed while a transfer is still in flight.

A write lowers chip-select, then lowers write-enable one cycle later for the programmed pulse width. Chip-select, address and data are held until the programmed write cycle count has elapsed, which sets the hold time after write-enable rises. A read lowers chip-select, lowers output-enable after a programmed delay, samples the input data bus in the last cycle and then releases both strobes together. An optional multiplexed mode puts the address on the data-out bus in the first transfer cycle. In that mode, write data follows on the same bus from the next cycle.

Every transfer ends with a one-cycle done pulse. Read data is presented with that pulse.

Top module: `sram_cycle_engine`

## Requirements
- R1: After reset all chip-select lines, write-enable and output-enable are high, address and data-out are zero, reqReady is high, rspDone is low and rspRdata is zero.
- R2: During a transfer exactly the chip-select line numbered by reqCs (bit reqCs of memCsN) is low, and every other line stays high. The first low cycle is the second cycle after acceptance.
- R3: In a write, memWeN goes low exactly one cycle after memCsN goes low and stays low for cfgWePulse cycles. A pulse value of 0 gives one cycle.
- R4: A write keeps chip-select low for max(cfgWrCycles, P+1) cycles, where P is the effective pulse width. memAddr holds the request address throughout. In non-multiplexed mode memDout holds the write data throughout; in a non-multiplexed read memDout is zero.
- R5: In a read, memOeN goes low D cycles after memCsN goes low, where D is cfgOeDelay. memCsN and memOeN rise together after max(cfgRdCycles, D+1) cycles.
- R6: A read returns on rspRdata the value on memDin during its last chip-select cycle. A write leaves rspRdata unchanged.
- R7: With cfgMux high, memDout carries the zero-extended address in the first chip-select cycle and the write data (zero for reads) afterwards. Write-enable never falls before the data phase, and a zero output-enable delay is raised to 1.
- R8: A request is accepted only while reqReady is high, and reqReady stays low until the transfer ends. The end is a single-cycle rspDone with all strobes high and reqReady high.
- R9: memWeN and memOeN are never low together. A read never lowers memWeN, and a write never lowers memOeN.
- R10: Changing any cfg input or cfgMux after acceptance does not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle, request will be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCs | input | 2 | Chip-select index |
| reqAddr | input | 32 | Transfer address |
| reqWdata | input | 32 | Write data |
| cfgWrCycles | input | 4 | Total write cycle count |
| cfgWePulse | input | 3 | Write-enable low width in cycles |
| cfgRdCycles | input | 4 | Total read cycle count |
| cfgOeDelay | input | 3 | Cycles from chip-select low to output-enable low |
| cfgMux | input | 1 | Multiplexed address/data mode |
| memCsN | output | 4 | Active-low chip-selects |
| memWeN | output | 1 | Active-low write-enable |
| memOeN | output | 1 | Active-low output-enable |
| memAddr | output | 32 | Address bus |
| memDout | output | 32 | Data-out bus (address then data when multiplexed) |
| memDin | input | 32 | Read data from memory |
| rspRdata | output | 32 | Captured read data |
| rspDone | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench targets several corner cases, each of which shows up as a distinct fault:
- A zero pulse width: a design that ignores the clamp would never lower write-enable.
- A write count shorter than the pulse: a design that trusts the raw count would release chip-select while write-enable is still low.
- An output-enable delay at or beyond the read count: a design would end the read without output-enable.
- A multiplexed read with zero delay: a design would lower output-enable while the address occupies the bus.
- Configuration scrambled right after acceptance: a design sampling live registers would change strobe widths mid-transfer.
- Back-to-back requests: a design would not return chip-select high between transfers.
- A changing memDin: a design capturing one cycle early or late would return the wrong word.

// File: rtl/sram_eng_pkg.sv
package sram_eng_pkg;

  typedef struct packed {
    logic csOn;
    logic weOn;
    logic oeOn;
    logic addrPhase;
    logic capture;
    logic finish;
  } pinStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } engState_e;

endpackage

// File: rtl/sram_eng_ctrl.sv
module sram_eng_ctrl
  import sram_eng_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int PW    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [CNT_W-1:0] cfgWrCycles,
  input  logic [PW-1:0]    cfgWePulse,
  input  logic [CNT_W-1:0] cfgRdCycles,
  input  logic [PW-1:0]    cfgOeDelay,
  input  logic             cfgMux,
  output logic             reqReady,
  output logic             accept,
  output pinStrobes_t      strb
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  engState_e        state;
  logic [CNT_W-1:0] cnt, lastCnt, weLen, oeStart;
  logic             isWr;
  logic [CNT_W-1:0] wpEff, oeEff, wrTotal, rdTotal;

  // effective timings derived from the live configuration, latched on accept
  always_comb begin
    wpEff   = (cfgWePulse == '0) ? ONE : CNT_W'(cfgWePulse);
    oeEff   = (cfgMux && cfgOeDelay == '0) ? ONE : CNT_W'(cfgOeDelay);
    wrTotal = (cfgWrCycles > wpEff) ? cfgWrCycles : wpEff + ONE;
    rdTotal = (cfgRdCycles > oeEff) ? cfgRdCycles : oeEff + ONE;
  end

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      lastCnt <= '0;
      weLen   <= '0;
      oeStart <= '0;
      isWr    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state   <= ST_RUN;
          cnt     <= '0;
          isWr    <= reqWrite;
          weLen   <= wpEff;
          oeStart <= oeEff;
          lastCnt <= (reqWrite ? wrTotal : rdTotal) - ONE;
        end
        ST_RUN: begin
          if (cnt == lastCnt) state <= ST_FIN;
          else                cnt   <= cnt + ONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    if (state == ST_RUN) begin
      strb.csOn      = 1'b1;
      strb.addrPhase = (cnt == '0);
      strb.weOn      = isWr && (cnt != '0) && (cnt <= weLen);
      strb.oeOn      = !isWr && (cnt >= oeStart);
    end else if (state == ST_FIN) begin
      strb.finish  = 1'b1;
      strb.capture = !isWr;
    end
  end

  // R8: once taken, no second request until the transfer ends
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

  // R9: the two enables are never requested together
  assert_enables_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.weOn && strb.oeOn));

endmodule

// File: rtl/sram_eng_dp.sv
module sram_eng_dp
  import sram_eng_pkg::*;
#(
  parameter int CS_N   = 4,
  parameter int CSEL_W = 2,
  parameter int AW     = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accept,
  input  pinStrobes_t       strb,
  input  logic              reqWrite,
  input  logic [CSEL_W-1:0] reqCs,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DW-1:0]     reqWdata,
  input  logic              cfgMux,
  input  logic [DW-1:0]     memDin,
  output logic [CS_N-1:0]   memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memDout,
  output logic [DW-1:0]     rspRdata,
  output logic              rspDone
);

  logic [AW-1:0]     addrQ;
  logic [DW-1:0]     wdataQ;
  logic [CSEL_W-1:0] selQ;
  logic              muxQ, wrQ;
  logic [CS_N-1:0]   csDec;
  logic [DW-1:0]     doutNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      selQ   <= '0;
      muxQ   <= 1'b0;
      wrQ    <= 1'b0;
    end else if (accept) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      selQ   <= reqCs;
      muxQ   <= cfgMux;
      wrQ    <= reqWrite;
    end
  end

  for (genvar i = 0; i < CS_N; i++) begin : g_csDecode
    assign csDec[i] = strb.csOn && (selQ == CSEL_W'(i));
  end

  always_comb begin
    doutNext = '0;
    if (strb.csOn) begin
      if (muxQ && strb.addrPhase) doutNext = DW'(addrQ);
      else if (wrQ)               doutNext = wdataQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCsN   <= '1;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      memAddr  <= '0;
      memDout  <= '0;
      rspRdata <= '0;
      rspDone  <= 1'b0;
    end else begin
      memCsN  <= ~csDec;
      memWeN  <= ~strb.weOn;
      memOeN  <= ~strb.oeOn;
      memAddr <= strb.csOn ? addrQ : '0;
      memDout <= doutNext;
      rspDone <= strb.finish;
      if (strb.capture) rspRdata <= memDin;
    end
  end

  // R2: never more than one chip-select line low
  assert_single_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  // R3: write-enable falls only when chip-select was already low a cycle earlier
  assert_we_lags_cs_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> (memCsN != '1) && ($past(memCsN) != '1));

  // R3: write-enable is only low inside a chip-select window
  assert_we_inside_cs_R3: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memCsN != '1));

  // R4: address is held while the same chip-select stays low
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((memCsN != '1) && ($past(memCsN) == memCsN)) |-> $stable(memAddr));

  // R9: enables never overlap on the pins
  assert_pin_enables_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

// File: rtl/sram_cycle_engine.sv
module sram_cycle_engine
  import sram_eng_pkg::*;
#(
  parameter int CS_N  = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 4,
  parameter int PW    = 3,
  localparam int CSEL_W = (CS_N > 1) ? $clog2(CS_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [CSEL_W-1:0] reqCs,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DW-1:0]     reqWdata,
  input  logic [CNT_W-1:0]  cfgWrCycles,
  input  logic [PW-1:0]     cfgWePulse,
  input  logic [CNT_W-1:0]  cfgRdCycles,
  input  logic [PW-1:0]     cfgOeDelay,
  input  logic              cfgMux,
  output logic [CS_N-1:0]   memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memDout,
  input  logic [DW-1:0]     memDin,
  output logic [DW-1:0]     rspRdata,
  output logic              rspDone
);

  pinStrobes_t strb;
  logic        accept;

  sram_eng_ctrl #(.CNT_W(CNT_W), .PW(PW)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .cfgWrCycles(cfgWrCycles), .cfgWePulse(cfgWePulse),
    .cfgRdCycles(cfgRdCycles), .cfgOeDelay(cfgOeDelay), .cfgMux(cfgMux),
    .reqReady(reqReady), .accept(accept), .strb(strb)
  );

  sram_eng_dp #(.CS_N(CS_N), .CSEL_W(CSEL_W), .AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .accept(accept), .strb(strb),
    .reqWrite(reqWrite), .reqCs(reqCs), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgMux(cfgMux), .memDin(memDin),
    .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN), .memAddr(memAddr),
    .memDout(memDout), .rspRdata(rspRdata), .rspDone(rspDone)
  );

endmodule

// File: tb/sram_cycle_engine_test.sv
module sram_cycle_engine_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, cfgMux = 1'b0;
  logic        reqReady, memWeN, memOeN, rspDone;
  logic [1:0]  reqCs = '0;
  logic [31:0] reqAddr = '0, reqWdata = '0, memDin = '0;
  logic [3:0]  cfgWrCycles = '0, cfgRdCycles = '0;
  logic [2:0]  cfgWePulse = '0, cfgOeDelay = '0;
  logic [3:0]  memCsN;
  logic [31:0] memAddr, memDout, rspRdata;

  int checks = 0, errors = 0;
  logic [31:0] lastRd = '0;

  always #4 clk = ~clk;

  sram_cycle_engine uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqCs(reqCs), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgWrCycles(cfgWrCycles), .cfgWePulse(cfgWePulse),
    .cfgRdCycles(cfgRdCycles), .cfgOeDelay(cfgOeDelay), .cfgMux(cfgMux),
    .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN), .memAddr(memAddr),
    .memDout(memDout), .memDin(memDin), .rspRdata(rspRdata), .rspDone(rspDone)
  );

  function automatic int wpOf(int wp);
    return (wp == 0) ? 1 : wp;
  endfunction
  function automatic int wrLen(int wc, int wp);
    return (wc > wpOf(wp)) ? wc : wpOf(wp) + 1;
  endfunction
  function automatic int oeAt(int ceoe, bit mux);
    return (mux && ceoe == 0) ? 1 : ceoe;
  endfunction
  function automatic int rdLen(int rc, int ceoe, bit mux);
    return (rc > oeAt(ceoe, mux)) ? rc : oeAt(ceoe, mux) + 1;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one transfer starting at a negedge with the engine idle; returns at
  // the negedge of the done cycle.
  task automatic xfer(bit wr, logic [31:0] a, logic [31:0] d, int sel,
                      int wc, int wp, int rc, int ceoe, bit mux);
    int len, wpe, oes;
    logic [31:0] pat, expD;
    logic [3:0]  expCs;
    check(reqReady == 1'b1, "R8 ready before request", 64'(reqReady), 64'd1);
    reqWrite = wr; reqAddr = a; reqWdata = d; reqCs = 2'(sel);
    cfgWrCycles = 4'(wc); cfgWePulse = 3'(wp);
    cfgRdCycles = 4'(rc); cfgOeDelay = 3'(ceoe); cfgMux = mux;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    // R10: scramble configuration and request fields after acceptance
    cfgWrCycles = 4'($urandom); cfgWePulse = 3'($urandom);
    cfgRdCycles = 4'($urandom); cfgOeDelay = 3'($urandom);
    cfgMux = 1'($urandom); reqAddr = $urandom; reqWdata = $urandom;
    reqCs = 2'($urandom); reqWrite = 1'($urandom);
    check(memCsN == 4'hF, "R2 no select before first cycle", 64'(memCsN), 64'hF);
    check(reqReady == 1'b0, "R8 busy after accept", 64'(reqReady), 64'd0);
    pat = $urandom;
    wpe = wpOf(wp);
    oes = oeAt(ceoe, mux);
    len = wr ? wrLen(wc, wp) : rdLen(rc, ceoe, mux);
    expCs = ~(4'b0001 << sel);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      memDin = pat ^ 32'(k);
      check(memCsN == expCs, "R2 R10 chip select", 64'(memCsN), 64'(expCs));
      if (wr) begin
        check(memWeN == !(k >= 1 && k <= wpe), "R3 R10 write enable",
              64'(memWeN), 64'(!(k >= 1 && k <= wpe)));
        check(memOeN == 1'b1, "R9 no output enable on write", 64'(memOeN), 64'd1);
      end else begin
        check(memOeN == !(k >= oes), "R5 R10 output enable",
              64'(memOeN), 64'(!(k >= oes)));
        check(memWeN == 1'b1, "R9 no write enable on read", 64'(memWeN), 64'd1);
      end
      check(memAddr == a, "R4 address held", 64'(memAddr), 64'(a));
      expD = (mux && k == 0) ? a : (wr ? d : 32'h0);
      check(memDout == expD, mux ? "R7 muxed data bus" : "R4 data bus",
            64'(memDout), 64'(expD));
      check(rspDone == 1'b0, "R8 no early done", 64'(rspDone), 64'd0);
    end
    @(negedge clk);
    check(memCsN == 4'hF && memWeN && memOeN, "R8 strobes released",
          64'({memCsN, memWeN, memOeN}), 64'h3F);
    check(rspDone == 1'b1, "R8 done pulse", 64'(rspDone), 64'd1);
    check(reqReady == 1'b1, "R8 ready at done", 64'(reqReady), 64'd1);
    if (!wr) lastRd = pat ^ 32'(len - 1);
    check(rspRdata == lastRd, wr ? "R6 write keeps read data" : "R6 read capture",
          64'(rspRdata), 64'(lastRd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(memCsN == 4'hF && memWeN && memOeN, "R1 strobes high",
          64'({memCsN, memWeN, memOeN}), 64'h3F);
    check(memAddr == 0 && memDout == 0, "R1 buses zero", 64'({memAddr, memDout}), 64'd0);
    check(reqReady && !rspDone && rspRdata == 0, "R1 handshake idle",
          64'({reqReady, rspDone, rspRdata}), 64'h1_0000_0000 << 1);
    rstN = 1'b1;
    @(negedge clk);
    check(memCsN == 4'hF, "R1 idle after reset", 64'(memCsN), 64'hF);

    // directed corners
    xfer(1, 32'h1000_0040, 32'hCAFE_0001, 2, 4, 2, 0, 0, 0); // R3 R4 nominal
    xfer(1, 32'h2000_0000, 32'h1234_5678, 0, 3, 0, 0, 0, 0); // R3 zero pulse
    xfer(1, 32'h0000_0ABC, 32'hDEAD_BEEF, 3, 0, 5, 0, 0, 0); // R4 extend short count
    xfer(1, 32'hFFFF_FFFC, 32'h0F0F_0F0F, 1, 15, 7, 0, 0, 0); // R4 longest
    xfer(0, 32'h0000_0100, 32'h0, 1, 0, 0, 0, 0, 0);          // R5 minimum read
    xfer(0, 32'h0000_0200, 32'h0, 2, 0, 0, 3, 7, 0);          // R5 delay past count
    xfer(0, 32'h0000_0300, 32'h0, 0, 0, 0, 9, 2, 0);          // R6 long read
    xfer(1, 32'h4000_0010, 32'hA5A5_5A5A, 3, 5, 3, 0, 0, 1);  // R7 muxed write
    xfer(0, 32'h4000_0020, 32'h0, 1, 0, 0, 4, 0, 1);          // R7 muxed read zero delay
    xfer(1, 32'h4000_0030, 32'h5555_AAAA, 0, 0, 0, 0, 0, 1);  // R7 muxed write minimum

    for (int n = 0; n < 60; n++) begin
      xfer(1'($urandom), $urandom, $urandom, int'($urandom_range(0, 3)),
           int'($urandom_range(0, 15)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 15)), int'($urandom_range(0, 7)), 1'($urandom));
    end
    @(negedge clk);
    check(rspDone == 1'b0, "R8 done lasts one cycle", 64'(rspDone), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule